// File: doc/BRIEF.md
# Floating-Point Significand Normalizer

This block takes the raw significand produced by a floating-point subtraction, where cancellation can leave leading zeros, and brings it back to normalized form with a 1 in its top position. It finds the highest set bit and turns that bit's position directly into a left-shift count. A logarithmic shifter then applies the count, filling the vacated low positions with zeros. The block also produces an exponent reduced by the same count.

The work is done in one pass of combinational logic. There is no loop that shifts one place and tests again. When the significand width is a power of two, the shift count is the bitwise inverse of the index of the highest set bit. For other widths it is the width minus one, minus that index. An all-zero significand cannot be normalized. In that case a zero flag is raised and the data passes through without being shifted. Rounding, exponent underflow and denormal handling belong to other blocks. The exponent result wraps modulo its width.

Top module: `fp_norm_shifter`

## Requirements
- R1: `is_zero` is 1 exactly when every bit of `sig_in` is 0.
- R2: For any non-zero `sig_in`, bit SIG_W-1 of `sig_out` is 1.
- R3: `shamt` equals the number of leading zeros of a non-zero `sig_in`, which is SIG_W-1 minus the index of its highest set bit (the bitwise inverse of that index for power-of-two widths). Example for SIG_W=8: input 00000101 gives shamt 5 and output 10100000.
- R4: `sig_out` equals `sig_in` shifted left by `shamt` places, with zeros entering at bit 0 and no set bit shifted out.
- R5: `exp_out` equals `exp_in` minus `shamt`, taken modulo 2^EXP_W.
- R6: For an all-zero `sig_in`, `sig_out` is 0, `shamt` is 0 and `exp_out` equals `exp_in`.
- R7: An input that already has bit SIG_W-1 set passes through unchanged, with `shamt` 0 and `exp_out` equal to `exp_in`.
- R8: An input with only bit 0 set gives the largest shift, SIG_W-1. The output is then a lone 1 in bit SIG_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sig_in | input | SIG_W | Significand to normalize |
| exp_in | input | EXP_W | Exponent that goes with `sig_in` |
| sig_out | output | SIG_W | Normalized significand |
| shamt | output | $clog2(SIG_W) | Left-shift count that was applied |
| exp_out | output | EXP_W | Exponent reduced by `shamt` (wraps) |
| is_zero | output | 1 | High when `sig_in` is all zeros |

## Verification
The bound checker re-checks a set of relations every time an input changes. It checks that the zero flag agrees with the input, and that the top output bit is set whenever the input is non-zero. It checks that shifting the output back right by the reported count restores the input exactly, which proves no set bit was lost. It checks that the count added to the output exponent gives back the input exponent. It also checks that a zero input leaves the data unshifted. Only the bench's scenarios can show that the count is the minimal, leading-zero-exact value. They are the exhaustive sweep of all 8-bit significands against an arithmetic leading-zero count, paired with varied exponents that include wrap-around. The boundary inputs with only the top bit or only bit 0 set are named in the bench.

// File: rtl/nrm_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the significand normalizer.
// Assumes widths are positive compile-time constants.
package nrm_pkg;
    // Returns 1 when n is a power of two (n > 0).
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction
endpackage

// File: rtl/nrm_lead_one.sv
`timescale 1ns/1ps
// Leading-one locator: reports the index of the highest set bit and
// converts it into the left-shift count needed to move that bit to
// the top. Assumes SIG_W >= 2. For an all-zero input, found=0 and
// the count is forced to 0.
module nrm_lead_one #(
    parameter int SIG_W = 8,
    localparam int K = $clog2(SIG_W)
) (
    input  logic [SIG_W-1:0] vec,
    output logic             found,
    output logic [K-1:0]     count
);
    localparam logic [K-1:0] TOP_IDX = K'(SIG_W - 1);

    logic [K-1:0] idx;
    logic [K-1:0] cnt_raw;

    // Priority scan: the highest set bit wins because it is visited last.
    always_comb begin
        idx = '0;
        for (int i = 0; i < SIG_W; i++) begin
            if (vec[i]) idx = K'(i);
        end
    end

    // Any bit set at all.
    assign found = |vec;

    // Count derivation: bit inversion for power-of-two widths, subtraction otherwise.
    generate
        if (nrm_pkg::is_pow2(SIG_W)) begin : g_inv
            assign cnt_raw = ~idx;
        end else begin : g_sub
            assign cnt_raw = TOP_IDX - idx;
        end
    endgenerate

    // Zero input requests no shift.
    assign count = found ? cnt_raw : '0;
endmodule

// File: rtl/nrm_log_shift.sv
`timescale 1ns/1ps
// Logarithmic left shifter: stage i moves the data left by 2**i places
// when sel[i] is 1, shifting zeros in at bit 0. No wrap-around.
module nrm_log_shift #(
    parameter int SIG_W = 8,
    localparam int K = $clog2(SIG_W)
) (
    input  logic [SIG_W-1:0] din,
    input  logic [K-1:0]     sel,
    output logic [SIG_W-1:0] dout
);
    logic [SIG_W-1:0] stg [K+1];

    // Stage input feed.
    assign stg[0] = din;

    generate
        for (genvar i = 0; i < K; i++) begin : g_stage
            // One binary-weighted shift step, selected by one count bit.
            assign stg[i+1] = sel[i] ? (stg[i] << (2 ** i)) : stg[i];
        end
    endgenerate

    // Last stage is the result.
    assign dout = stg[K];
endmodule

// File: rtl/nrm_exp_adj.sv
`timescale 1ns/1ps
// Exponent adjuster: lowers the exponent by the shift count, modulo
// 2**EXP_W. Assumes EXP_W >= CNT_W. Underflow is left to later logic.
module nrm_exp_adj #(
    parameter int EXP_W = 8,
    parameter int CNT_W = 3
) (
    input  logic [EXP_W-1:0] e_in,
    input  logic [CNT_W-1:0] dec,
    output logic [EXP_W-1:0] e_out
);
    localparam int PAD_W = EXP_W - CNT_W;

    logic [EXP_W-1:0] dec_ext;

    // Zero-extend the count to exponent width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign dec_ext = {{PAD_W{1'b0}}, dec};
        end else begin : g_nopad
            assign dec_ext = dec;
        end
    endgenerate

    // Wrapping subtraction.
    assign e_out = e_in - dec_ext;
endmodule

// File: rtl/fp_norm_shifter.sv
`timescale 1ns/1ps
// Significand normalizer top: locate the leading one, shift left in a
// single combinational pass, and lower the exponent by the same count.
// Purely combinational; an all-zero significand raises is_zero and is
// passed through unshifted.
module fp_norm_shifter #(
    parameter int SIG_W = 8,
    parameter int EXP_W = 8,
    localparam int K = $clog2(SIG_W)
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0] sig_out,
    output logic [K-1:0]     shamt,
    output logic [EXP_W-1:0] exp_out,
    output logic             is_zero
);
    logic         any_one;
    logic [K-1:0] cnt;

    // Find the top set bit and derive the shift count.
    nrm_lead_one #(.SIG_W(SIG_W)) u_lod (
        .vec   (sig_in),
        .found (any_one),
        .count (cnt)
    );

    // Apply the count through the staged shifter.
    nrm_log_shift #(.SIG_W(SIG_W)) u_shf (
        .din  (sig_in),
        .sel  (cnt),
        .dout (sig_out)
    );

    // Lower the exponent by the applied count.
    nrm_exp_adj #(.EXP_W(EXP_W), .CNT_W(K)) u_exp (
        .e_in  (exp_in),
        .dec   (cnt),
        .e_out (exp_out)
    );

    // Output drive.
    assign shamt   = cnt;
    assign is_zero = ~any_one;
endmodule

// File: rtl/fp_norm_shifter_chk.sv
`timescale 1ns/1ps
// Checker for fp_norm_shifter: relations between its ports, evaluated
// whenever any of them changes. Bound to every instance of the top.
module fp_norm_shifter_chk #(
    parameter int SIG_W = 8,
    parameter int EXP_W = 8,
    localparam int K = $clog2(SIG_W)
) (
    input logic [SIG_W-1:0] sig_in,
    input logic [EXP_W-1:0] exp_in,
    input logic [SIG_W-1:0] sig_out,
    input logic [K-1:0]     shamt,
    input logic [EXP_W-1:0] exp_out,
    input logic             is_zero
);
    // Port relations re-checked on every change.
    always_comb begin
        // R1
        zero_flag_chk: assert (is_zero == (sig_in == '0));
        // R2
        msb_set_chk: assert (is_zero || sig_out[SIG_W-1]);
        // R4
        no_lost_one_chk: assert ((sig_out >> shamt) == sig_in);
        // R5
        exp_track_chk: assert (EXP_W'(exp_out + EXP_W'(shamt)) == exp_in);
        // R6
        zero_pass_chk: assert (!is_zero || (shamt == '0 && sig_out == '0));
    end
endmodule

bind fp_norm_shifter fp_norm_shifter_chk #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (
    .sig_in  (sig_in),
    .exp_in  (exp_in),
    .sig_out (sig_out),
    .shamt   (shamt),
    .exp_out (exp_out),
    .is_zero (is_zero)
);

// File: tb/sim_fp_norm_shifter.sv
`timescale 1ns/1ps
module sim_fp_norm_shifter;
    localparam int SW = 8;
    localparam int EW = 8;

    logic clk = 1'b0;
    logic [SW-1:0] sig_in;
    logic [EW-1:0] exp_in;
    logic [SW-1:0] sig_out;
    logic [2:0]    shamt;
    logic [EW-1:0] exp_out;
    logic          is_zero;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fp_norm_shifter #(.SIG_W(SW), .EXP_W(EW)) u0 (
        .sig_in (sig_in), .exp_in (exp_in), .sig_out (sig_out),
        .shamt (shamt), .exp_out (exp_out), .is_zero (is_zero)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (sig_in=%b exp_in=%0d)",
                     tag, act, exp, sig_in, exp_in);
        end
    endtask

    // Drive on the falling edge, sample 1 ns later.
    task automatic apply(input int s, input int e);
        @(negedge clk);
        sig_in = SW'(s);
        exp_in = EW'(e);
        #1;
    endtask

    function automatic int lzc(input int s);
        for (int b = SW - 1; b >= 0; b--)
            if (s[b]) return SW - 1 - b;
        return SW;
    endfunction

    initial begin
        sig_in = '0;
        exp_in = '0;
        // Initial state: zero significand (R6, R1)
        apply(0, 0);
        check("R1 zero flag at start", int'(is_zero), 1);
        check("R6 zero output at start", int'(sig_out), 0);

        // R3 worked example: 00000101 -> shift 5, 10100000
        apply(5, 40);
        check("R3 example shamt", int'(shamt), 5);
        check("R3 example sig_out", int'(sig_out), 160);
        check("R5 example exp_out", int'(exp_out), 35);

        // R7 already normalized input
        apply(8'hC3, 17);
        check("R7 unchanged sig", int'(sig_out), 8'hC3);
        check("R7 zero shift", int'(shamt), 0);
        check("R7 exp unchanged", int'(exp_out), 17);

        // R8 only bit 0 set: largest shift
        apply(1, 100);
        check("R8 max shift", int'(shamt), SW - 1);
        check("R8 lone top bit", int'(sig_out), 128);

        // R5 wrap-around: exponent smaller than shift
        apply(3, 2);
        check("R5 wrap exp", int'(exp_out), (2 - 6) & 8'hFF);

        // R6 zero input with nonzero exponent keeps exponent
        apply(0, 77);
        check("R6 exp pass", int'(exp_out), 77);
        check("R6 shamt zero", int'(shamt), 0);

        // Exhaustive sweep over all significands with varied exponents
        for (int v = 0; v < 256; v++) begin
            int e;
            int lz;
            e = (v * 37 + 11) & 8'hFF;
            apply(v, e);
            lz = lzc(v);
            check("R1 zero flag", int'(is_zero), (v == 0) ? 1 : 0);
            if (v == 0) begin
                check("R6 sig zero", int'(sig_out), 0);
                check("R6 shamt zero", int'(shamt), 0);
                check("R6 exp same", int'(exp_out), e);
            end else begin
                check("R2 msb set", int'(sig_out[SW-1]), 1);
                check("R3 shamt", int'(shamt), lz);
                check("R4 shifted data", int'(sig_out), (v << lz) & 8'hFF);
                check("R5 exp adjust", int'(exp_out), (e - lz) & 8'hFF);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule